// File: doc/BRIEF.md
# Five-State Sequence Counter

This block is a three-bit counter whose state bits, named C (most significant), B and A (least significant), walk a fixed five-step loop that is not binary order. The loop, written as the code CBA, is 000, 010, 011, 101, 110 and back to 000. The counter moves one step on a rising clock edge only while the count enable is high. The three state bits are its only output.

Three codes are not on the loop: 001, 100 and 111. The next-state logic is written as plain sum-of-products equations with one D register per bit. Those equations fix a defined successor for each unused code. So if the register ever lands on one of these codes, the counter rejoins the loop within two counts.

The reset input is active low. Its assertion clears the state at once, without waiting for a clock edge. Its release passes through a small synchronizer before the register leaves reset.

Top module: `seqcnt5`

## Requirements
- R1: Driving `rst_n` low forces `cnt_q` to 000 right away, before the next rising clock edge, whatever the state and enable were.
- R2: After `rst_n` rises, `cnt_q` stays at 000 for the first SYNC_STAGES (default 2) rising edges even with `cnt_en` high. The first advance, to 010, happens on the next edge after those.
- R3: While `cnt_en` is high, each rising edge moves the state along the loop 000 → 010 → 011 → 101 → 110 → 000. Bit 2 of `cnt_q` is C, bit 1 is B and bit 0 is A.
- R4: While `cnt_en` is low, the state holds through a rising edge. This applies to loop codes and unused codes alike.
- R5: From unused code 001, one count gives 110.
- R6: From unused code 100, one count gives 010.
- R7: From unused code 111, one count gives 100, and a second count gives 010.
- R8: From any unused code, at most two counts bring the state back onto the loop.
- R9: For all eight codes, the successor equals the current code XOR the toggle vector. The toggle vector is T_C = A xor C, T_B = A or C or not B, and T_A = A xor (B and not C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; assertion takes effect at once, release is synchronized |
| cnt_en | input | 1 | Count enable; high advances the state on the next rising edge |
| cnt_q | output | 3 | State bits {C, B, A} |

## Verification
Two events can land on the same edge: the release of reset and a count request. The bench holds `cnt_en` high as `rst_n` rises. It expects the state to stay at 000 through the synchronizer edges and to reach 010 only on the edge after them. Random reset pulses in the middle of counting also drop `rst_n` between edges. The bench then checks that the output is 000 before the next edge arrives. Unused codes are placed in the register just after reset release. Their recovery is then judged count by count against a reference table in the bench and against toggle-form equations.

// File: rtl/seqcnt5_pkg.sv
`timescale 1ns/1ps
package seqcnt5_pkg;

  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_ZERO  = 3'b000;
  localparam code_t CODE_TWO   = 3'b010;
  localparam code_t CODE_THREE = 3'b011;
  localparam code_t CODE_FIVE  = 3'b101;
  localparam code_t CODE_SIX   = 3'b110;

  // Bit positions of the three state bits inside a code.
  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;

  // D-register next state, one sum-of-products term set per bit.
  function automatic code_t seq_next(input code_t cur);
    logic c, b, a;
    code_t nxt;
    c = cur[BIT_C];
    b = cur[BIT_B];
    a = cur[BIT_A];
    nxt[BIT_C] = a;
    nxt[BIT_B] = (~a & ~c) | ~b;
    nxt[BIT_A] = b & ~c;
    return nxt;
  endfunction

  // True for the five codes on the counting loop.
  function automatic logic seq_in_cycle(input code_t cur);
    return (cur == CODE_ZERO) || (cur == CODE_TWO) || (cur == CODE_THREE) ||
           (cur == CODE_FIVE) || (cur == CODE_SIX);
  endfunction

endpackage

// File: rtl/seqcnt5_rst_sync.sv
`timescale 1ns/1ps
module seqcnt5_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_r;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_r <= 1'b0;
        else         stage_r <= 1'b1;
      end
      assign srst_n = stage_r;
    end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_r <= '0;
        else         chain_r <= {chain_r[STAGES-2:0], 1'b1};
      end
      assign srst_n = chain_r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/seqcnt5_next.sv
`timescale 1ns/1ps
module seqcnt5_next
  import seqcnt5_pkg::*;
(
  input  code_t cur,
  input  logic  adv,
  output code_t nxt
);

  code_t step_code;

  always_comb begin
    step_code = seq_next(cur);
    nxt       = adv ? step_code : cur;
  end

endmodule

// File: rtl/seqcnt5_reg.sv
`timescale 1ns/1ps
module seqcnt5_reg
  import seqcnt5_pkg::*;
(
  input  logic  clk,
  input  logic  clr_n,
  input  code_t d,
  output code_t q
);

  code_t q_r;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_r <= CODE_ZERO;
    else        q_r <= d;
  end

  assign q = q_r;

endmodule

// File: rtl/seqcnt5.sv
`timescale 1ns/1ps
module seqcnt5
  import seqcnt5_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  output logic [2:0] cnt_q
);

  logic  clr_n;
  logic  rst_sync_n;
  code_t state_cur;
  code_t state_d;

  seqcnt5_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // Assertion of rst_n clears the register at once; release follows the synchronizer.
  assign clr_n = rst_sync_n & rst_n;

  seqcnt5_next u_next (
    .cur (state_cur),
    .adv (cnt_en),
    .nxt (state_d)
  );

  seqcnt5_reg u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (state_d),
    .q     (state_cur)
  );

  assign cnt_q = state_cur;

endmodule

// File: rtl/seqcnt5_chk.sv
`timescale 1ns/1ps
module seqcnt5_chk
  import seqcnt5_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic       cnt_en,
  input logic [2:0] state
);

  AST_ASYNC_CLEAR: assert property (@(posedge clk) !rst_n |-> state == CODE_ZERO); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !cnt_en) |=> $stable(state)); // R4

  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && cnt_en && seq_in_cycle(state)) |=>
      (seq_in_cycle(state) && state != $past(state))); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && cnt_en && state == CODE_SIX) |=> state == CODE_ZERO); // R3

  AST_RECOVER_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && cnt_en && !seq_in_cycle(state)) |=>
      (seq_in_cycle(state) || state == 3'b100)); // R8

  AST_RECOVER_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && cnt_en && state == 3'b100) |=> state == CODE_TWO); // R6

endmodule

bind seqcnt5 seqcnt5_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cnt_en     (cnt_en),
  .state      (cnt_q)
);

// File: tb/seqcnt5_tb.sv
`timescale 1ns/1ps
module seqcnt5_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] cnt_q;
  logic [2:0] exp_q = 3'b000;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  seqcnt5 u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .cnt_q  (cnt_q)
  );

  // Reference successor written as a lookup of the loop and the recovery codes.
  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      3'b110:  return 3'b000;
      3'b001:  return 3'b110;
      3'b100:  return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  // Successor in toggle form: s xor {T_C, T_B, T_A}.
  function automatic logic [2:0] tog_next(input logic [2:0] s);
    logic tc, tb, ta;
    tc = s[0] ^ s[2];
    tb = s[0] | s[2] | ~s[1];
    ta = s[0] ^ (s[1] & ~s[2]);
    return s ^ {tc, tb, ta};
  endfunction

  function automatic bit on_loop(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) || (s == 3'b101) || (s == 3'b110);
  endfunction

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input bit en, input string req);
    @(negedge clk);
    cnt_en = en;
    @(posedge clk);
    #1;
    if (en) exp_q = ref_next(exp_q);
    chk(req, cnt_q, exp_q);
  endtask

  // Reset pulse with cnt_en held high through the release; ends just after the
  // last synchronizer edge, so the next edge is the first that may count.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    exp_q = 3'b000;
    chk("R1", cnt_q, 3'b000);
    @(negedge clk);
    rst_n  = 1'b1;
    cnt_en = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      chk("R2", cnt_q, 3'b000);
    end
  endtask

  task automatic inject(input logic [2:0] code);
    do_reset();
    force u_dut.u_reg.q_r = code;
    #0.5;
    release u_dut.u_reg.q_r;
    exp_q = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4093));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", cnt_q, 3'b000);

    // Reset release coinciding with a count request, then three full loops.
    do_reset();
    step(1'b1, "R2");
    for (int i = 0; i < 14; i++) step(1'b1, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, "R4");

    // Mid-loop asynchronous clear.
    step(1'b1, "R3");
    do_reset();

    inject(3'b001); step(1'b1, "R5"); step(1'b1, "R5");
    inject(3'b100); step(1'b1, "R6");
    inject(3'b111); step(1'b1, "R7"); step(1'b1, "R7");
    inject(3'b001); step(1'b0, "R4"); step(1'b0, "R4");
    inject(3'b111); step(1'b0, "R4");

    // Bounded return to the loop.
    for (int u = 0; u < 3; u++) begin
      logic [2:0] code;
      int hops;
      code = (u == 0) ? 3'b001 : (u == 1) ? 3'b100 : 3'b111;
      inject(code);
      hops = 0;
      while (!on_loop(exp_q) && hops < 2) begin
        step(1'b1, "R8");
        hops++;
      end
      checks++;
      if (!on_loop(cnt_q)) begin
        fails++;
        $display("FAIL R8 got=%b exp=on-loop code from %b", cnt_q, code);
      end
    end

    // Toggle-form equivalence over every code.
    for (int c = 0; c < 8; c++) begin
      inject(3'(c));
      @(negedge clk);
      cnt_en = 1'b1;
      @(posedge clk);
      #1;
      exp_q = tog_next(3'(c));
      chk("R9", cnt_q, exp_q);
    end

    // Random mix of counting, holding, resets and unused-code injection.
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 4) begin
        int pick;
        pick = int'($urandom % 3);
        inject((pick == 0) ? 3'b001 : (pick == 1) ? 3'b100 : 3'b111);
      end else if (r < 7) begin
        do_reset();
      end else if (r < 75) begin
        step(1'b1, on_loop(exp_q) ? "R3" : "R8");
      end else begin
        step(1'b0, "R4");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule